// File: doc/BRIEF.md
# Multi-mode LUT slice cell

This cell is one function generator of a logic slice. It holds sixteen storage bits and reads one of them out through a four-bit select. The same bits can work in three ways. They can be a truth table, so any function of four inputs is possible. They can be a small memory that reads at one address and writes at another address in the same cycle. They can be a shift register whose output tap is chosen by the select.

A carry mux sits beside the storage and builds one bit of a ripple adder. To use it, the table is loaded with the exclusive-or of the two operand bits. The carry mux then passes the incoming carry when that bit is high, and passes operand A when it is low. The sum is the table output exclusive-ored with the incoming carry.

The table is loaded through the same synchronous write port that the memory mode uses.

Top module: `lut_slice_cell`

## Requirements
- R1: An active-low `rst_n` clears all sixteen storage bits to 0, so `func_out` reads 0 for every value of `rd_sel`.
- R2: `func_out` always equals the stored bit whose index is `rd_sel`, and follows changes of `rd_sel` and of the stored bits without waiting for a clock edge.
- R3: With `mode` at 2'b00 (table mode; 2'b11 behaves the same), a rising edge with `wr_en` high writes `wr_data` into the bit at index `wr_addr`. This is how the table is configured.
- R4: With `mode` at 2'b01 (memory mode), a rising edge with `wr_en` high writes `wr_data` at `wr_addr` while reads use `rd_sel` on their own. When the address being read is written, `func_out` shows the old bit until that edge and the new bit after it.
- R5: With `mode` at 2'b10 (shift mode), a rising edge with `shift_en` high moves every bit up one index, drops bit 15 and loads `wr_data` into bit 0. Tap 0 is therefore the newest bit.
- R6: In shift mode `wr_en` and `wr_addr` are ignored. With `shift_en` low the contents hold.
- R7: Outside shift mode `shift_en` is ignored. With `wr_en` low the contents hold.
- R8: `sum_out` equals `func_out` xor `carry_in`.
- R9: `carry_out` equals `carry_in` when `func_out` is 1, and equals `op_a` when `func_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 00/11 table, 01 memory, 10 shift |
| rd_sel | input | 4 | Read address / function inputs / tap select |
| wr_addr | input | 4 | Write address for table load and memory mode |
| wr_data | input | 1 | Bit written or shifted in |
| wr_en | input | 1 | Write enable (table and memory modes) |
| shift_en | input | 1 | Shift enable (shift mode) |
| carry_in | input | 1 | Incoming carry |
| op_a | input | 1 | Operand bit A passed to carry-out when no propagate |
| func_out | output | 1 | Selected storage bit |
| sum_out | output | 1 | Sum bit |
| carry_out | output | 1 | Outgoing carry |

## Verification
The assertions check, on every clock, how the storage changes. A write lands at the written address, a shift moves every bit and brings in the new one, and the contents hold whenever the active mode's enable is low. They also check at each clock that the sum and carry outputs agree with the function output.

Some behaviour only the bench scenarios can show. These are the read-before-write view within a cycle, the ordering of taps after a run of shifts, the full truth table of an adder bit built from a loaded exclusive-or, and the reset contents.

// File: rtl/lut_slice_cell.sv
module lut_slice_cell #(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic [SEL_W-1:0] rd_sel,
  input  logic [SEL_W-1:0] wr_addr,
  input  logic             wr_data,
  input  logic             wr_en,
  input  logic             shift_en,
  input  logic             carry_in,
  input  logic             op_a,
  output logic             func_out,
  output logic             sum_out,
  output logic             carry_out
);
  localparam int DEPTH = 1 << SEL_W;
  localparam logic [1:0] MODE_SHIFT = 2'b10;

  logic [DEPTH-1:0] cells;
  logic             shift_mode;

  assign shift_mode = (mode == MODE_SHIFT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cells <= '0;
    else if (shift_mode) begin
      if (shift_en) cells <= {cells[DEPTH-2:0], wr_data};
    end else if (wr_en)
      cells[wr_addr] <= wr_data;
  end

  assign func_out  = cells[rd_sel];
  assign sum_out   = func_out ^ carry_in;
  assign carry_out = func_out ? carry_in : op_a;

  assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_mode && wr_en) |=> cells[$past(wr_addr)] == $past(wr_data));

  assert_hold_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_mode && !wr_en) |=> $stable(cells));

  assert_shift_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_mode && shift_en) |=>
      (cells[0] == $past(wr_data)) && (cells[DEPTH-1:1] == $past(cells[DEPTH-2:0])));

  assert_shift_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_mode && !shift_en) |=> $stable(cells));

  assert_sum_matches_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_out ^ func_out) == carry_in);

  assert_carry_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (carry_out != carry_in) |-> (!func_out && carry_out == op_a));
endmodule

// File: tb/lut_slice_cell_tb.sv
module lut_slice_cell_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [3:0] rd_sel = '0;
  logic [3:0] wr_addr = '0;
  logic       wr_data = 1'b0;
  logic       wr_en = 1'b0;
  logic       shift_en = 1'b0;
  logic       carry_in = 1'b0;
  logic       op_a = 1'b0;
  logic       func_out, sum_out, carry_out;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lut_slice_cell u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .rd_sel(rd_sel), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_en(wr_en), .shift_en(shift_en), .carry_in(carry_in),
    .op_a(op_a), .func_out(func_out), .sum_out(sum_out), .carry_out(carry_out)
  );

  // {a, b, cin, expected sum, expected carry}
  localparam logic [4:0] ADD_VEC [8] = '{
    5'b000_00, 5'b001_10, 5'b010_10, 5'b011_01,
    5'b100_10, 5'b101_01, 5'b110_01, 5'b111_11
  };

  task automatic chk(input string req, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic write_bit(input logic [3:0] a, input logic d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic shift_bit(input logic d);
    @(negedge clk);
    shift_en = 1'b1; wr_data = d;
    @(negedge clk);
    shift_en = 1'b0;
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    // R1: reset contents
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 16; i++) begin
      rd_sel = 4'(i); #1;
      chk("R1 reset clear", func_out, 1'b0);
    end

    // R3: load exclusive-or of rd_sel[0], rd_sel[1] in table mode
    mode = 2'b00;
    for (int i = 0; i < 16; i++) write_bit(4'(i), logic'(i[0] ^ i[1]));
    for (int i = 0; i < 16; i++) begin
      rd_sel = 4'(i); #1;
      chk("R2/R3 table readback", func_out, logic'(i[0] ^ i[1]));
    end

    // R8 R9: adder bit vectors
    for (int v = 0; v < 8; v++) begin
      rd_sel   = {2'b00, ADD_VEC[v][3], ADD_VEC[v][4]};
      op_a     = ADD_VEC[v][4];
      carry_in = ADD_VEC[v][2];
      #1;
      chk("R8 sum", sum_out, ADD_VEC[v][1]);
      chk("R9 carry", carry_out, ADD_VEC[v][0]);
    end

    // R4: memory mode, read-before-write at the same address
    mode = 2'b01;
    @(negedge clk);
    rd_sel = 4'd5; wr_addr = 4'd5; wr_data = 1'b0; wr_en = 1'b1;
    #1 chk("R4 old data before edge", func_out, 1'b1);
    @(posedge clk); #1;
    chk("R4 new data after edge", func_out, 1'b0);
    @(negedge clk); wr_en = 1'b0;
    // R4: write elsewhere while reading an independent address
    rd_sel = 4'd3;
    write_bit(4'd12, 1'b1);
    #1 chk("R4 independent read", func_out, 1'b0);
    rd_sel = 4'd12; #1;
    chk("R4 written bit", func_out, 1'b1);

    // R7: shift_en ignored outside shift mode
    shift_bit(1'b1);
    rd_sel = 4'd0; #1 chk("R7 shift ignored bit0", func_out, 1'b0);
    rd_sel = 4'd1; #1 chk("R7 shift ignored bit1", func_out, 1'b1);

    // R6: write port ignored in shift mode
    mode = 2'b10;
    write_bit(4'd0, 1'b1);
    rd_sel = 4'd0; #1 chk("R6 write ignored", func_out, 1'b0);

    // R5: shift in 1,0,1,1 (last is newest)
    shift_bit(1'b1); shift_bit(1'b0); shift_bit(1'b1); shift_bit(1'b1);
    rd_sel = 4'd0; #1 chk("R5 tap0 newest", func_out, 1'b1);
    rd_sel = 4'd1; #1 chk("R5 tap1", func_out, 1'b1);
    rd_sel = 4'd2; #1 chk("R5 tap2", func_out, 1'b0);
    rd_sel = 4'd3; #1 chk("R5 tap3", func_out, 1'b1);
    rd_sel = 4'd4; #1 chk("R5 tap4 old bit0", func_out, 1'b0);
    rd_sel = 4'd5; #1 chk("R5 tap5 old bit1", func_out, 1'b1);

    // R6: hold with shift_en low
    repeat (3) @(negedge clk);
    rd_sel = 4'd0; #1 chk("R6 hold", func_out, 1'b1);

    // R1: reset again mid-run
    rst_n = 1'b0; #1;
    rd_sel = 4'd1; #1 chk("R1 reset clears again", func_out, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    done = 1'b1;
    report();
  end
endmodule